// File: doc/BRIEF.md
# Segment Table Address Translator

This block turns logical addresses from a user-mode requester into physical addresses. It uses a small on-chip table of segments. The top bits of a logical address choose one table entry and the low bits are the offset into that segment. Each entry holds a physical base, an inclusive limit on the offset, and separate read-permission and write-permission bits. For every request the block checks the offset against the limit and the access type against the permissions. One cycle later it returns either the relocated address (base plus offset) or a fault code.

Privileged software maintains the table through a configuration port. Writes are accepted only while the privileged-mode input is high. A write attempted in user mode leaves the table untouched and raises a one-cycle error flag. Every field of every entry can be read back in privileged mode, so the table can be saved and restored on a context switch. Reads made in user mode return zeros.

Top module: `seg_xlate`

## Requirements
- R1: The top `SEG_BITS` bits of `req_laddr` (bits 15:14 by default) select the table entry, and the low `LADDR_W-SEG_BITS` bits (bits 13:0) are the offset.
- R2: For an accepted request with no fault, `rsp_valid` is 1 in the cycle after `req_valid`, `rsp_fault` is 2'b00 and `rsp_paddr` equals (base + offset) modulo 2^PADDR_W.
- R3: When the offset is greater than the entry's limit, `rsp_fault` is 2'b01 (bounds) and `rsp_paddr` is 0.
- R4: A write (`req_write`=1) to an entry whose write bit is 0, or a read to an entry whose read bit is 0, gives `rsp_fault` 2'b10 (protection) and `rsp_paddr` 0.
- R5: An entry with both permission bits cleared is invalid: every in-limit access to it, read or write, gives `rsp_fault` 2'b10.
- R6: When the bounds check and the permission check both fail, `rsp_fault` is 2'b01. The code 2'b11 never appears.
- R7: With `priv`=1, a pulse on `cfg_we` stores `cfg_wbase`, `cfg_wlimit`, `cfg_wrd` and `cfg_wwr` into entry `cfg_idx`. Requests from the next cycle onward use the new values. With `priv`=1, the `cfg_r*` outputs show every field of entry `cfg_idx` combinationally.
- R8: A `cfg_we` pulse with `priv`=0 leaves the table unchanged and drives `cfg_err` to 1 for exactly the following cycle.
- R9: While `priv`=0, all `cfg_r*` outputs read 0.
- R10: After reset every entry is 0 (base 0, limit 0, no permissions), and `rsp_valid`, `rsp_fault`, `rsp_paddr` and `cfg_err` are 0.
- R11: In a cycle following one without `req_valid`, `rsp_valid`, `rsp_paddr` and `rsp_fault` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| priv | input | 1 | Privileged mode; enables table writes and readback |
| req_valid | input | 1 | Translation request present |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_laddr | input | 16 | Logical address (segment number and offset) |
| rsp_valid | output | 1 | Response present, one cycle after request |
| rsp_paddr | output | 16 | Physical address, 0 on fault |
| rsp_fault | output | 2 | 00 ok, 01 bounds, 10 protection |
| cfg_idx | input | 2 | Entry addressed by the configuration port |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wbase | input | 16 | Base to store |
| cfg_wlimit | input | 14 | Inclusive offset limit to store |
| cfg_wrd | input | 1 | Read permission to store |
| cfg_wwr | input | 1 | Write permission to store |
| cfg_rbase | output | 16 | Readback of base |
| cfg_rlimit | output | 14 | Readback of limit |
| cfg_rrd | output | 1 | Readback of read permission |
| cfg_rwr | output | 1 | Readback of write permission |
| cfg_err | output | 1 | User-mode write attempt flagged |

## Verification
The bench builds the block with its defaults: 16-bit logical and physical addresses and two segment bits, which give four entries with a 14-bit offset. At that size the bench cycles all four permission combinations through every entry. For each entry it sweeps read and write accesses at offset 0, at the limit, at the limit plus and minus one, at the largest offset and at a spread of interior points. This covers limits of 0 and full range, and a base high enough that base plus offset wraps. Mode gating of writes and readback is checked on every entry.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;
  localparam int unsigned DEF_LADDR_W  = 16;
  localparam int unsigned DEF_SEG_BITS = 2;
  localparam int unsigned DEF_PADDR_W  = 16;

  typedef enum logic [1:0] {
    FLT_NONE   = 2'b00,
    FLT_BOUNDS = 2'b01,
    FLT_PROT   = 2'b10
  } fault_e;

  // Bounds outranks protection.
  function automatic fault_e pick_fault(input logic bounds, input logic perm);
    if (bounds)    return FLT_BOUNDS;
    else if (perm) return FLT_PROT;
    else           return FLT_NONE;
  endfunction
endpackage

// File: rtl/seg_table.sv
module seg_table #(
  parameter int unsigned SEG_BITS = 2,
  parameter int unsigned PADDR_W  = 16,
  parameter int unsigned OFF_W    = 14,
  localparam int unsigned NSEG    = 1 << SEG_BITS,
  localparam int unsigned EW      = PADDR_W + OFF_W + 2,
  localparam int unsigned TBL_W   = NSEG * EW
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [SEG_BITS-1:0] wr_idx,
  input  logic [EW-1:0]       wr_ent,
  input  logic [SEG_BITS-1:0] xl_idx,
  output logic [EW-1:0]       xl_ent,
  input  logic [SEG_BITS-1:0] cf_idx,
  output logic [EW-1:0]       cf_ent,
  output logic [TBL_W-1:0]    tbl_flat
);
  // Entry layout: {base, limit, rd, wr}
  for (genvar g = 0; g < NSEG; g++) begin : g_ent
    logic [EW-1:0] ent_q;
    logic          hit;
    assign hit = wr_en && (wr_idx == SEG_BITS'(g));
    always_ff @(posedge clk) begin
      if (!rst_n)   ent_q <= '0;
      else if (hit) ent_q <= wr_ent;
    end
    assign tbl_flat[g*EW +: EW] = ent_q;
  end

  assign xl_ent = tbl_flat[xl_idx*EW +: EW];
  assign cf_ent = tbl_flat[cf_idx*EW +: EW];
endmodule

// File: rtl/seg_check.sv
module seg_check
  import seg_xlate_pkg::*;
#(
  parameter int unsigned PADDR_W = 16,
  parameter int unsigned OFF_W   = 14,
  localparam int unsigned EW     = PADDR_W + OFF_W + 2
) (
  input  logic [EW-1:0]      ent,
  input  logic [OFF_W-1:0]   offset,
  input  logic               write,
  output logic [PADDR_W-1:0] paddr,
  output logic               bounds_hit,
  output logic               perm_hit,
  output fault_e             fault
);
  logic [PADDR_W-1:0] base;
  logic [OFF_W-1:0]   limit;
  logic               rd_ok, wr_ok;

  assign {base, limit, rd_ok, wr_ok} = ent;

  function automatic logic [PADDR_W-1:0] reloc(input logic [PADDR_W-1:0] b,
                                               input logic [OFF_W-1:0]   o);
    logic [PADDR_W+OFF_W:0] s;
    s = (PADDR_W+OFF_W+1)'(b) + (PADDR_W+OFF_W+1)'(o);
    return s[PADDR_W-1:0];
  endfunction

  function automatic logic over_limit(input logic [OFF_W-1:0] o,
                                      input logic [OFF_W-1:0] l);
    return o > l;
  endfunction

  function automatic logic denied(input logic w, input logic r_ok, input logic w_ok);
    return w ? !w_ok : !r_ok;
  endfunction

  assign paddr      = reloc(base, offset);
  assign bounds_hit = over_limit(offset, limit);
  assign perm_hit   = denied(write, rd_ok, wr_ok);
  assign fault      = pick_fault(bounds_hit, perm_hit);
endmodule

// File: rtl/seg_resp.sv
module seg_resp
  import seg_xlate_pkg::*;
#(
  parameter int unsigned PADDR_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [PADDR_W-1:0] in_paddr,
  input  fault_e             in_fault,
  output logic               rsp_valid,
  output logic [PADDR_W-1:0] rsp_paddr,
  output logic [1:0]         rsp_fault
);
  logic clean;
  assign clean = in_valid && (in_fault == FLT_NONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_paddr <= '0;
      rsp_fault <= 2'b00;
    end else begin
      rsp_valid <= in_valid;
      rsp_paddr <= clean ? in_paddr : '0;
      rsp_fault <= in_valid ? in_fault : FLT_NONE;
    end
  end
endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
  import seg_xlate_pkg::*;
#(
  parameter int unsigned LADDR_W  = DEF_LADDR_W,
  parameter int unsigned SEG_BITS = DEF_SEG_BITS,
  parameter int unsigned PADDR_W  = DEF_PADDR_W,
  localparam int unsigned OFF_W   = LADDR_W - SEG_BITS
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                priv,
  input  logic                req_valid,
  input  logic                req_write,
  input  logic [LADDR_W-1:0]  req_laddr,
  output logic                rsp_valid,
  output logic [PADDR_W-1:0]  rsp_paddr,
  output logic [1:0]          rsp_fault,
  input  logic [SEG_BITS-1:0] cfg_idx,
  input  logic                cfg_we,
  input  logic [PADDR_W-1:0]  cfg_wbase,
  input  logic [OFF_W-1:0]    cfg_wlimit,
  input  logic                cfg_wrd,
  input  logic                cfg_wwr,
  output logic [PADDR_W-1:0]  cfg_rbase,
  output logic [OFF_W-1:0]    cfg_rlimit,
  output logic                cfg_rrd,
  output logic                cfg_rwr,
  output logic                cfg_err
);
  localparam int unsigned NSEG  = 1 << SEG_BITS;
  localparam int unsigned EW    = PADDR_W + OFF_W + 2;
  localparam int unsigned TBL_W = NSEG * EW;

  // Named internal events, observed by the bound checker.
  logic                cfg_write_ok;
  logic                cfg_write_blocked;
  logic                bounds_hit;
  logic                perm_hit;
  logic [TBL_W-1:0]    tbl_flat;

  logic [SEG_BITS-1:0] seg_idx;
  logic [OFF_W-1:0]    offset;
  logic [EW-1:0]       xl_ent, cf_ent, wr_ent;
  logic [PADDR_W-1:0]  paddr_nxt;
  fault_e              fault_nxt;

  assign seg_idx = req_laddr[LADDR_W-1 -: SEG_BITS];
  assign offset  = req_laddr[OFF_W-1:0];

  assign cfg_write_ok      = cfg_we &&  priv;
  assign cfg_write_blocked = cfg_we && !priv;
  assign wr_ent            = {cfg_wbase, cfg_wlimit, cfg_wrd, cfg_wwr};

  seg_table #(.SEG_BITS(SEG_BITS), .PADDR_W(PADDR_W), .OFF_W(OFF_W)) u_table (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cfg_write_ok),
    .wr_idx  (cfg_idx),
    .wr_ent  (wr_ent),
    .xl_idx  (seg_idx),
    .xl_ent  (xl_ent),
    .cf_idx  (cfg_idx),
    .cf_ent  (cf_ent),
    .tbl_flat(tbl_flat)
  );

  seg_check #(.PADDR_W(PADDR_W), .OFF_W(OFF_W)) u_check (
    .ent       (xl_ent),
    .offset    (offset),
    .write     (req_write),
    .paddr     (paddr_nxt),
    .bounds_hit(bounds_hit),
    .perm_hit  (perm_hit),
    .fault     (fault_nxt)
  );

  seg_resp #(.PADDR_W(PADDR_W)) u_resp (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (req_valid),
    .in_paddr (paddr_nxt),
    .in_fault (fault_nxt),
    .rsp_valid(rsp_valid),
    .rsp_paddr(rsp_paddr),
    .rsp_fault(rsp_fault)
  );

  // Readback only in privileged mode.
  assign {cfg_rbase, cfg_rlimit, cfg_rrd, cfg_rwr} = priv ? cf_ent : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) cfg_err <= 1'b0;
    else        cfg_err <= cfg_write_blocked;
  end
endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk #(
  parameter int unsigned PADDR_W = 16,
  parameter int unsigned TBL_W   = 128
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic               rsp_valid,
  input logic [PADDR_W-1:0] rsp_paddr,
  input logic [1:0]         rsp_fault,
  input logic               bounds_hit,
  input logic               perm_hit,
  input logic               cfg_write_ok,
  input logic               cfg_write_blocked,
  input logic               cfg_err,
  input logic [TBL_W-1:0]   tbl_flat
);
  // R2
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!rsp_valid && rsp_paddr == '0 && rsp_fault == 2'b00));

  // R3
  fault_no_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_fault != 2'b00) |-> (rsp_paddr == '0));

  // R6
  bounds_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && bounds_hit) |=> (rsp_fault == 2'b01));

  // R4
  perm_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !bounds_hit && perm_hit) |=> (rsp_fault == 2'b10));

  // R6
  no_code3_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fault != 2'b11);

  // R8
  user_write_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_write_blocked |=> cfg_err);

  // R8
  flag_only_after_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_write_blocked |=> !cfg_err);

  // R8
  table_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_write_ok |=> $stable(tbl_flat));
endmodule

bind seg_xlate seg_xlate_chk #(.PADDR_W(PADDR_W), .TBL_W(TBL_W)) u_chk (.*);

// File: tb/seg_xlate_bench.sv
module seg_xlate_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        priv, req_valid, req_write;
  logic [15:0] req_laddr;
  logic        rsp_valid;
  logic [15:0] rsp_paddr;
  logic [1:0]  rsp_fault;
  logic [1:0]  cfg_idx;
  logic        cfg_we;
  logic [15:0] cfg_wbase;
  logic [13:0] cfg_wlimit;
  logic        cfg_wrd, cfg_wwr;
  logic [15:0] cfg_rbase;
  logic [13:0] cfg_rlimit;
  logic        cfg_rrd, cfg_rwr;
  logic        cfg_err;

  int checks = 0;
  int fails  = 0;

  // Bench model of the table
  int mb[4];
  int ml[4];
  int mr[4];
  int mw[4];

  always #(CLK_PERIOD/2) clk = ~clk;

  seg_xlate u_seg_xlate (.*);

  task automatic check(input string tag, input logic ok, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic cfg_write(input int idx, input int base, input int lim,
                           input int r, input int w, input logic p);
    @(negedge clk);
    priv = p; cfg_idx = 2'(idx); cfg_we = 1'b1;
    cfg_wbase = 16'(base); cfg_wlimit = 14'(lim); cfg_wrd = r[0]; cfg_wwr = w[0];
    @(negedge clk);
    cfg_we = 1'b0;
    if (p) begin
      mb[idx] = base & 16'hFFFF; ml[idx] = lim & 14'h3FFF; mr[idx] = r & 1; mw[idx] = w & 1;
      // R8 flag stays low for privileged writes
      check("R8", cfg_err == 1'b0, "cfg_err after priv write", cfg_err, 0);
    end else begin
      // R8 flag raised in the following cycle
      check("R8", cfg_err == 1'b1, "cfg_err after user write", cfg_err, 1);
    end
    priv = 1'b1;
  endtask

  task automatic readback(input int idx);
    @(negedge clk);
    priv = 1'b1; cfg_idx = 2'(idx);
    #1;
    // R7 readback of every field
    check("R7", cfg_rbase == 16'(mb[idx]) && cfg_rlimit == 14'(ml[idx]) &&
          cfg_rrd == mr[idx][0] && cfg_rwr == mw[idx][0], "readback",
          {cfg_rbase, cfg_rlimit, cfg_rrd, cfg_rwr},
          {16'(mb[idx]), 14'(ml[idx]), mr[idx][0], mw[idx][0]});
  endtask

  task automatic xlate(input logic w, input int seg, input int off);
    int  ef, ep;
    bit  bnd, prm;
    string tag;
    @(negedge clk);
    req_valid = 1'b1; req_write = w;
    req_laddr = 16'((seg << 14) | (off & 16'h3FFF));
    bnd = (off > ml[seg]);
    prm = w ? (mw[seg] == 0) : (mr[seg] == 0);
    if (bnd)      begin ef = 1; ep = 0; tag = prm ? "R6" : "R3"; end
    else if (prm) begin ef = 2; ep = 0; tag = (mr[seg] == 0 && mw[seg] == 0) ? "R5" : "R4"; end
    else          begin ef = 0; ep = (mb[seg] + off) & 16'hFFFF; tag = "R1/R2"; end
    @(negedge clk);
    req_valid = 1'b0;
    check(tag, rsp_valid == 1'b1 && rsp_fault == 2'(ef) && rsp_paddr == 16'(ep),
          "{valid,fault,paddr}", {rsp_valid, rsp_fault, rsp_paddr},
          {1'b1, 2'(ef), 16'(ep)});
  endtask

  task automatic sweep_seg(input int seg);
    int offs[10];
    offs[0] = 0; offs[1] = ml[seg]; offs[2] = ml[seg] + 1; offs[3] = 16383;
    offs[4] = (ml[seg] > 0) ? ml[seg] - 1 : 1;
    offs[5] = 821; offs[6] = 4099; offs[7] = 8191; offs[8] = 8192; offs[9] = 12345;
    for (int k = 0; k < 10; k++) begin
      if (offs[k] <= 16383) begin
        xlate(1'b0, seg, offs[k]);
        xlate(1'b1, seg, offs[k]);
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int bases[4];
    int lims[4];
    bases[0] = 16'h0000; bases[1] = 16'h2A00; bases[2] = 16'h9150; bases[3] = 16'hF000;
    lims[0]  = 14'h3FFF; lims[1]  = 0;        lims[2]  = 14'h1234; lims[3]  = 14'h0FFF;
    for (int i = 0; i < 4; i++) begin mb[i] = 0; ml[i] = 0; mr[i] = 0; mw[i] = 0; end
    rst_n = 1'b0; priv = 1'b1; req_valid = 1'b0; req_write = 1'b0; req_laddr = '0;
    cfg_idx = '0; cfg_we = 1'b0; cfg_wbase = '0; cfg_wlimit = '0; cfg_wrd = 1'b0; cfg_wwr = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R10 reset state
    check("R10", rsp_valid == 0 && rsp_paddr == 0 && rsp_fault == 0 && cfg_err == 0,
          "outputs after reset", {rsp_valid, rsp_paddr, rsp_fault, cfg_err}, 0);
    for (int i = 0; i < 4; i++) readback(i);   // R10 entries cleared

    // R5 cleared entries fault within limit
    xlate(1'b0, 2, 0);
    xlate(1'b1, 2, 0);

    // Sweep every permission combination over every entry (R1..R6)
    for (int p = 0; p < 4; p++) begin
      for (int i = 0; i < 4; i++) begin
        int pc;
        pc = (i + p) % 4;
        cfg_write(i, bases[i] + p * 16'h0111, lims[i], pc >> 1, pc & 1, 1'b1);
      end
      for (int i = 0; i < 4; i++) readback(i);
      for (int i = 0; i < 4; i++) sweep_seg(i);
    end

    // R11 idle cycle
    @(negedge clk);
    check("R11", rsp_valid == 0 && rsp_paddr == 0 && rsp_fault == 0,
          "idle outputs", {rsp_valid, rsp_paddr, rsp_fault}, 0);

    // R8 user-mode writes ignored and flagged
    for (int i = 0; i < 4; i++) begin
      cfg_write(i, 16'h5555, 14'h0001, 0, 0, 1'b0);
      @(negedge clk);
      check("R8", cfg_err == 1'b0, "cfg_err one cycle only", cfg_err, 0);
      readback(i);
      sweep_seg(i);
    end

    // R9 user-mode readback is zero
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      priv = 1'b0; cfg_idx = 2'(i);
      #1;
      check("R9", cfg_rbase == 0 && cfg_rlimit == 0 && cfg_rrd == 0 && cfg_rwr == 0,
            "user readback", {cfg_rbase, cfg_rlimit, cfg_rrd, cfg_rwr}, 0);
    end
    priv = 1'b1;

    // R7 new entry used by the next request; R2 wraparound
    cfg_write(3, 16'hFFF0, 14'h3FFF, 1, 1, 1'b1);
    xlate(1'b1, 3, 16'h0020);
    xlate(1'b0, 3, 16'h3FFF);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule